// File: doc/BRIEF.md
# Local Bus Debug Trace Signaling

This block drives the debug side-band outputs of a local bus controller whose address and data share one set of wires. When debug mode is on, it gives a one-cycle data-valid strobe for every data beat. It also drives a five-bit source-ID bus. That bus names the internal requester of an access during the address phase, and names it again alongside each data beat. At all other times in debug mode the bus sits at all-ones. With debug mode off, both outputs stay quiet.

The protocol engine supplies the timing inputs:

- an address-latch-enable strobe;
- a flag marking the address-latch cycle in which the full physical address is on the bus;
- the direction of the access;
- a coded burst length;
- per-beat qualifiers, one for the cycle before read data is sampled and one for the last cycle in which write data is valid;
- its data transfer acknowledge.

The requester identifier is captured in the first address-latch cycle and held for the whole access, so a new request mid-burst cannot alter what is reported. A beat counter compares the beats seen against the coded burst length. A mismatch raises a sticky error flag.

Top module: `dbgtrace`

## Requirements
- R1: While dbgEn is low, dataValid is 0 and srcId is all-zeros in every cycle.
- R2: While dbgEn is high, srcId is all-ones in every cycle that has no data-valid pulse and is not an address-report cycle.
- R3: An address-report cycle is one where dbgEn, ale and addrFull are all high. In it, srcId carries the requester ID of the current access.
- R4: The requester ID of an access is the value of reqId in the first cycle of an ale assertion (ale high after a cycle with ale low). Later changes of reqId have no effect on srcId until the next ale assertion starts.
- R5: On a read (isRead=1), dataValid is high in exactly the cycles where dbgEn, ack and rdNext are all high, with no added latency.
- R6: On a write (isRead=0), dataValid is high in exactly the cycles where dbgEn, ack and wrLast are all high, with no added latency.
- R7: An ack without the qualifier for the current direction (rdNext on reads, wrLast on writes) produces no pulse, no ID report, and is not counted as a beat.
- R8: In a burst, each beat gives one single-cycle pulse, and srcId carries the access's captured ID in every pulse cycle.
- R9: beatCode, captured at the start of an ale assertion, codes the burst length as 0=1, 1=2, 2=4 and 3=8 beats. beatErr rises one cycle after a beat that exceeds the length or arrives before any access. It also rises one cycle after an ale start that ends an access with fewer beats.
- R10: beatErr stays high once set, until reset. Beats are counted whether or not dbgEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| dbgEn | input | 1 | Debug mode enable |
| ale | input | 1 | Address-latch-enable strobe |
| addrFull | input | 1 | Full physical address is on the bus this ale cycle |
| isRead | input | 1 | Access direction, 1 = read |
| beatCode | input | 2 | Coded burst length (0..3 = 1,2,4,8 beats) |
| rdNext | input | 1 | Read data is sampled in the next cycle |
| wrLast | input | 1 | Last cycle in which the current write data is valid |
| ack | input | 1 | Data transfer acknowledge from the protocol engine |
| reqId | input | 5 | Identifier of the requesting internal device |
| dataValid | output | 1 | Debug data-valid strobe |
| srcId | output | 5 | Debug source-ID bus |
| beatErr | output | 1 | Sticky beat-count mismatch flag |

## Verification
The bench uses the default parameters: five-bit IDs and a maximum burst of eight beats. This makes all four length codes reachable, including the longest burst, where an off-by-one in the counter would show. The tests cover several situations:

- reads and writes of each length, with debug mode toggled between accesses;
- requester changes inside the address phase and mid-burst;
- acknowledges that lack their direction qualifier;
- both the excess-beat and short-burst error paths, then reset to clear the flag.

// File: rtl/dbgtrace_pkg.sv
package dbgtrace_pkg;

  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic aleStart;   // first cycle of an ale assertion
    logic beat;       // qualified data beat
    logic addrShow;   // address-report cycle
  } trace_strobe_t;

endpackage

// File: rtl/dbgtrace_ctl.sv
module dbgtrace_ctl
  import dbgtrace_pkg::*;
#(
  parameter int MAX_BEATS = 8,
  parameter int CODE_W    = 2,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ale,
  input  logic              addrFull,
  input  logic              isRead,
  input  logic [CODE_W-1:0] beatCode,
  input  logic              rdNext,
  input  logic              wrLast,
  input  logic              ack,
  output trace_strobe_t     strb,
  output logic              beatErr
);

  logic             aleQ;
  logic             active;
  logic [CNT_W-1:0] beatCnt;
  logic [CNT_W-1:0] expBeats;
  logic [CNT_W-1:0] codeBeats;
  logic             errQ;
  logic             overRun;
  logic             shortEnd;

  // decode the burst length code into a beat count
  always_comb begin
    codeBeats = CNT_W'(1) << beatCode;
    if (codeBeats > CNT_W'(MAX_BEATS)) codeBeats = CNT_W'(MAX_BEATS);
  end

  always_comb begin
    strb.aleStart = ale & ~aleQ;
    strb.beat     = ack & (isRead ? rdNext : wrLast);
    strb.addrShow = ale & addrFull;
  end

  assign overRun  = strb.beat & (~active | (beatCnt == expBeats));
  assign shortEnd = strb.aleStart & active & (beatCnt != expBeats);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aleQ     <= 1'b0;
      active   <= 1'b0;
      beatCnt  <= '0;
      expBeats <= CNT_W'(1);
      errQ     <= 1'b0;
    end else begin
      aleQ <= ale;
      if (overRun || shortEnd) errQ <= 1'b1;
      if (strb.aleStart) begin
        active   <= 1'b1;
        expBeats <= codeBeats;
        beatCnt  <= strb.beat ? CNT_W'(1) : '0;
      end else if (strb.beat && !overRun) begin
        beatCnt <= beatCnt + CNT_W'(1);
      end
    end
  end

  assign beatErr = errQ;

endmodule

// File: rtl/dbgtrace_dp.sv
module dbgtrace_dp
  import dbgtrace_pkg::*;
#(
  parameter int ID_W = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            dbgEn,
  input  trace_strobe_t   strb,
  input  logic [ID_W-1:0] reqId,
  output logic [ID_W-1:0] srcId,
  output logic            dataValid
);

  localparam logic [ID_W-1:0] IDLE_ID = '1;
  localparam logic [ID_W-1:0] OFF_ID  = '0;

  logic [ID_W-1:0] heldId;
  logic [ID_W-1:0] addrId;

  always_ff @(posedge clk) begin
    if (!rstN)              heldId <= '0;
    else if (strb.aleStart) heldId <= reqId;
  end

  // first ale cycle reports the live request, later ones the capture
  assign addrId = strb.aleStart ? reqId : heldId;

  always_comb begin
    dataValid = dbgEn & strb.beat;
    if (!dbgEn)             srcId = OFF_ID;
    else if (strb.beat)     srcId = heldId;
    else if (strb.addrShow) srcId = addrId;
    else                    srcId = IDLE_ID;
  end

endmodule

// File: rtl/dbgtrace.sv
module dbgtrace
  import dbgtrace_pkg::*;
#(
  parameter int ID_W      = 5,
  parameter int MAX_BEATS = 8,
  localparam int CODE_W   = $clog2($clog2(MAX_BEATS) + 1),
  localparam int CNT_W    = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dbgEn,
  input  logic              ale,
  input  logic              addrFull,
  input  logic              isRead,
  input  logic [CODE_W-1:0] beatCode,
  input  logic              rdNext,
  input  logic              wrLast,
  input  logic              ack,
  input  logic [ID_W-1:0]   reqId,
  output logic              dataValid,
  output logic [ID_W-1:0]   srcId,
  output logic              beatErr
);

  trace_strobe_t strb;

  dbgtrace_ctl #(.MAX_BEATS(MAX_BEATS), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .ale(ale), .addrFull(addrFull), .isRead(isRead),
    .beatCode(beatCode), .rdNext(rdNext), .wrLast(wrLast), .ack(ack),
    .strb(strb), .beatErr(beatErr)
  );

  dbgtrace_dp #(.ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .dbgEn(dbgEn), .strb(strb), .reqId(reqId),
    .srcId(srcId), .dataValid(dataValid)
  );

endmodule

// File: rtl/dbgtrace_chk.sv
module dbgtrace_chk #(
  parameter int ID_W = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic            dbgEn,
  input logic            ale,
  input logic            addrFull,
  input logic            isRead,
  input logic            rdNext,
  input logic            wrLast,
  input logic            ack,
  input logic            dataValid,
  input logic [ID_W-1:0] srcId,
  input logic            beatErr
);

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !dbgEn |-> (!dataValid && srcId == '0));

  p_idle_ones_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dbgEn && !dataValid && !(ale && addrFull)) |-> (srcId == '1));

  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && isRead) |-> (ack && rdNext && dbgEn));

  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !isRead) |-> (ack && wrLast && dbgEn));

  p_no_bare_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !(isRead ? rdNext : wrLast)) |-> !dataValid);

  p_burst_id_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && $past(dataValid) && !$past(ale)) |-> (srcId == $past(srcId)));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(beatErr) |-> beatErr);

endmodule

bind dbgtrace dbgtrace_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .dbgEn(dbgEn), .ale(ale), .addrFull(addrFull),
  .isRead(isRead), .rdNext(rdNext), .wrLast(wrLast), .ack(ack),
  .dataValid(dataValid), .srcId(srcId), .beatErr(beatErr)
);

// File: tb/tb_dbgtrace.sv
module tb_dbgtrace;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       dv;
    logic [4:0] id;
    logic       err;
    logic [7:0] rq;
  } exp_t;

  logic       clk = 0;
  logic       rstN = 0;
  logic       dbgEn = 0, ale = 0, addrFull = 0, isRead = 0;
  logic [1:0] beatCode = 0;
  logic       rdNext = 0, wrLast = 0, ack = 0;
  logic [4:0] reqId = 0;
  logic       dataValid, beatErr;
  logic [4:0] srcId;

  int total = 0, bad = 0;
  bit finished = 0;
  exp_t expQ[$];

  // bench reference state
  bit       mPrevAle = 0, mActive = 0, mErr = 0;
  int       mCnt = 0, mExp = 1;
  bit [4:0] mHeld = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgtrace dut (
    .clk(clk), .rstN(rstN), .dbgEn(dbgEn), .ale(ale), .addrFull(addrFull),
    .isRead(isRead), .beatCode(beatCode), .rdNext(rdNext), .wrLast(wrLast),
    .ack(ack), .reqId(reqId), .dataValid(dataValid), .srcId(srcId),
    .beatErr(beatErr)
  );

  // one bus cycle: drive inputs, predict outputs, push the prediction
  task automatic cyc(input bit dbg, input bit al, input bit full, input bit rd,
                     input bit rdn, input bit wl, input bit ak,
                     input logic [4:0] req, input int rq);
    exp_t e;
    bit st, bt;
    bit [4:0] sel;
    @(posedge clk); #1;
    dbgEn = dbg; ale = al; addrFull = full; isRead = rd;
    rdNext = rdn; wrLast = wl; ack = ak; reqId = req;
    st  = al && !mPrevAle;
    bt  = ak && (rd ? rdn : wl);
    sel = st ? req : mHeld;
    e.dv  = dbg && bt;
    e.err = mErr;
    e.rq  = 8'(rq);
    if (!dbg)          e.id = 5'h00;
    else if (bt)       e.id = mHeld;
    else if (al && full) e.id = sel;
    else               e.id = 5'h1F;
    expQ.push_back(e);
    if (bt && (!mActive || mCnt == mExp)) mErr = 1;
    else if (bt && !st) mCnt++;
    if (st) begin
      if (mActive && mCnt != mExp) mErr = 1;
      mActive = 1; mCnt = bt ? 1 : 0; mExp = 1 << beatCode; mHeld = req;
    end
    mPrevAle = al;
  endtask

  task automatic idle(input int n, input bit dbg, input int rq);
    for (int i = 0; i < n; i++) cyc(dbg, 0, 0, isRead, 0, 0, 0, reqId, rq);
  endtask

  // two-cycle address phase; req changes in the second cycle
  task automatic addr(input bit dbg, input logic [1:0] code, input bit rd,
                      input logic [4:0] r0, input logic [4:0] r1, input int rq);
    beatCode = code;
    cyc(dbg, 1, 0, rd, 0, 0, 0, r0, rq);
    cyc(dbg, 1, 1, rd, 0, 0, 0, r1, rq);
  endtask

  task automatic beat(input bit dbg, input logic [4:0] req, input int rq);
    if (isRead) cyc(dbg, 0, 0, 1, 1, 0, 1, req, rq);
    else        cyc(dbg, 0, 0, 0, 0, 1, 1, req, rq);
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    rstN = 0; ale = 0; ack = 0; rdNext = 0; wrLast = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    mPrevAle = 0; mActive = 0; mErr = 0; mCnt = 0; mExp = 1; mHeld = 0;
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      total++;
      if (dataValid !== e.dv || srcId !== e.id || beatErr !== e.err) begin
        bad++;
        $display("FAIL R%0d: got dv=%b id=%h err=%b, expected dv=%b id=%h err=%b",
                 e.rq, dataValid, srcId, beatErr, e.dv, e.id, e.err);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    idle(3, 0, 1);                        // R1 reset / off state
    idle(2, 1, 2);                        // R2 debug idle all-ones
    // R3 R4 R5: single read, reqId changes during address phase
    addr(1, 2'd0, 1, 5'h0A, 5'h13, 4);
    idle(1, 1, 2);
    beat(1, 5'h07, 5);
    idle(1, 1, 2);
    // R7: read of two beats with a bare ack first
    addr(1, 2'd1, 1, 5'h05, 5'h05, 3);
    cyc(1, 0, 0, 1, 0, 0, 1, 5'h05, 7);
    beat(1, 5'h05, 5);
    beat(1, 5'h05, 8);
    idle(1, 1, 2);
    // R6 R8 R4: four-beat write, reqId changes mid-burst, a bare ack
    addr(1, 2'd2, 0, 5'h11, 5'h11, 3);
    beat(1, 5'h11, 6);
    cyc(1, 0, 0, 0, 1, 0, 1, 5'h02, 7);
    beat(1, 5'h02, 4);
    beat(1, 5'h1E, 8);
    beat(1, 5'h1E, 8);
    idle(1, 1, 2);
    // R1 R10: eight-beat read with debug off, still counted
    addr(0, 2'd3, 1, 5'h09, 5'h09, 1);
    for (int i = 0; i < 8; i++) beat(0, 5'h09, 1);
    idle(1, 0, 1);
    // debug back on, eight-beat read visible
    addr(1, 2'd3, 1, 5'h1C, 5'h03, 3);
    for (int i = 0; i < 8; i++) beat(1, 5'h03, 8);
    idle(1, 1, 2);
    // R9 excess beat on a single write
    addr(1, 2'd0, 0, 5'h04, 5'h04, 9);
    beat(1, 5'h04, 9);
    beat(1, 5'h04, 9);
    idle(2, 1, 9);
    // R10 sticky through a good access
    addr(1, 2'd0, 1, 5'h06, 5'h06, 10);
    beat(1, 5'h06, 10);
    idle(2, 1, 10);
    doReset();
    idle(2, 1, 10);                       // R10 cleared by reset
    // R9 short burst: two-beat read with one beat, ended by next ale
    addr(1, 2'd1, 1, 5'h08, 5'h08, 9);
    beat(1, 5'h08, 9);
    idle(1, 1, 9);
    addr(1, 2'd0, 1, 5'h0B, 5'h0B, 9);
    idle(2, 1, 9);
    // R9 beat before any access after reset
    doReset();
    beat(1, 5'h00, 9);
    idle(2, 1, 9);
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule